// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block is the column and data-timing core of a synchronous DRAM model. A mode command programs the burst length, the burst order (sequential or interleaved) and the read latency. A read or write command latches a bank and a starting column. The block then drives one column address per rising clock edge until the programmed burst is complete. A behavioural word array per bank takes the write data and returns read data. The read data comes out through a latency pipeline, together with a valid strobe.

A burst-stop command ends the column stream at once. Read words that are already inside the latency pipeline still come out. A new read or write accepted during a burst replaces the old burst on the same edge. Full-page bursts never end by themselves: they wrap around the row until a stop or a new command arrives.

Top module: `sdram_col_seq`

## Requirements
- R1: All inputs are sampled on the rising clock edge. A read (`cmd`=2) or write (`cmd`=3) sampled at edge E shows its starting column on `col_addr` and its bank on `col_bank`, with `col_vld` high, in the cycle after E. Beat n is shown in the cycle after edge E+n.
- R2: A mode command (`cmd`=1) with `mode_bl` equal to 0, 1, 2 or 3 sets the burst to 1, 2, 4 or 8 beats. The new setting applies to bursts started after that edge.
- R3: With `mode_il`=0, beat n uses column (S - S mod L) + ((S mod L + n) mod L), where S is the start column and L is the burst length.
- R4: With `mode_il`=1, beat n uses column S XOR n.
- R5: `mode_bl`=7 with `mode_il`=0 selects full page. The column advances by one per beat, wraps over all 512 columns and continues until a stop or a new read or write.
- R6: A mode command is ignored and the previous mode is kept when any of these holds: `mode_bl` is 4, 5 or 6; `mode_bl`=7 with `mode_il`=1; `mode_lat` is not 2 or 3.
- R7: `mode_lat` (2 or 3) sets the read latency. The word for a read beat sampled at edge E appears on `rd_data` with `rd_vld` high in the cycle after edge E+latency-1, so it is stable at edge E+latency.
- R8: A write beat at edge E stores the `wr_data` sampled at E in its bank and column. A later read beat of that location returns the stored word.
- R9: After a stop command (`cmd`=4) at edge E, `col_vld` is low from the cycle after E until the next read or write. Read words issued before E still appear at their normal latency.
- R10: A read or write sampled during an active burst ends the old burst and starts the new one at the same edge.
- R11: After a synchronous reset, `col_vld` and `rd_vld` are low and the mode is 1-beat, sequential, latency 2.
- R12: `col_wr` is high for write beats and low for read beats whenever `col_vld` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | 0 idle, 1 mode, 2 read, 3 write, 4 stop; other codes idle |
| cmd_bank | input | BANK_W | Bank of a read or write |
| cmd_col | input | COL_W | Starting column of a read or write |
| mode_bl | input | 3 | Burst length code for a mode command |
| mode_il | input | 1 | 1 selects interleaved order |
| mode_lat | input | 2 | Read latency for a mode command |
| wr_data | input | DATA_W | Write word for the beat at this edge |
| col_vld | output | 1 | A column beat was issued at the last edge |
| col_wr | output | 1 | That beat is a write |
| col_bank | output | BANK_W | Bank of that beat |
| col_addr | output | COL_W | Column of that beat |
| rd_vld | output | 1 | Read word valid |
| rd_data | output | DATA_W | Read word |

## Verification
Two situations are hard to reach from the ports: a stop or a new command landing while read words are still inside the latency pipeline, and a full-page burst that has run past the row end. Directed sequences place a stop and a replacing write on chosen beats of 8-beat bursts at latency 3, and they stop full-page bursts only after they have wrapped. A long random phase then fires stops, reads, writes and mode commands (illegal ones included) on arbitrary cycles against a bench reference model. That model covers every length, order and latency combination.

// File: rtl/sdram_col_pkg.sv
package sdram_col_pkg;
  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_MODE  = 3'd1,
    CMD_READ  = 3'd2,
    CMD_WRITE = 3'd3,
    CMD_STOP  = 3'd4
  } cmd_e;

  typedef struct packed {
    logic [2:0] bl;
    logic       il;
    logic [1:0] lat;
  } mode_t;

  localparam logic [2:0] BL_FULL = 3'd7;
endpackage

// File: rtl/sdram_mode_reg.sv
module sdram_mode_reg
  import sdram_col_pkg::*;
#(
  parameter int MIN_LAT = 2,
  parameter int MAX_LAT = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [2:0] bl_in,
  input  logic       il_in,
  input  logic [1:0] lat_in,
  output mode_t      mode
);
  logic bl_ok, lat_ok;

  // Fixed lengths are legal in both orders; full page only in sequential order.
  assign bl_ok  = (bl_in <= 3'd3) || ((bl_in == BL_FULL) && !il_in);
  assign lat_ok = (int'(lat_in) >= MIN_LAT) && (int'(lat_in) <= MAX_LAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= '{bl: 3'd0, il: 1'b0, lat: 2'(MIN_LAT)};
    end else if (load && bl_ok && lat_ok) begin
      mode <= '{bl: bl_in, il: il_in, lat: lat_in};
    end
  end
endmodule

// File: rtl/sdram_burst_gen.sv
module sdram_burst_gen
  import sdram_col_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  mode_t             mode,
  input  logic              start,
  input  logic              stop,
  input  logic              start_wr,
  input  logic [COL_W-1:0]  start_col,
  input  logic [BANK_W-1:0] start_bank,
  output logic              beat_go,
  output logic              beat_wr,
  output logic [COL_W-1:0]  beat_col,
  output logic [BANK_W-1:0] beat_bank
);
  logic              active_q;
  logic              wr_q;
  logic [COL_W-1:0]  base_q, cnt_q;
  logic [BANK_W-1:0] bank_q;
  logic              full;
  logic [COL_W-1:0]  mask, seq_col, il_col;

  assign full    = (mode.bl == BL_FULL);
  assign mask    = full ? {COL_W{1'b1}} : ~({COL_W{1'b1}} << mode.bl[1:0]);
  assign seq_col = (base_q & ~mask) | ((base_q + cnt_q) & mask);
  assign il_col  = base_q ^ (cnt_q & mask);

  // A beat for the current edge: a new command wins, stop silences.
  always_comb begin
    beat_go   = 1'b0;
    beat_wr   = wr_q;
    beat_col  = seq_col;
    beat_bank = bank_q;
    if (start) begin
      beat_go   = 1'b1;
      beat_wr   = start_wr;
      beat_col  = start_col;
      beat_bank = start_bank;
    end else if (active_q && !stop) begin
      beat_go  = 1'b1;
      beat_col = mode.il ? il_col : seq_col;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      wr_q     <= 1'b0;
      base_q   <= '0;
      cnt_q    <= '0;
      bank_q   <= '0;
    end else if (start) begin
      base_q   <= start_col;
      bank_q   <= start_bank;
      wr_q     <= start_wr;
      cnt_q    <= COL_W'(1);
      active_q <= (mask != '0);
    end else if (stop) begin
      active_q <= 1'b0;
    end else if (active_q) begin
      cnt_q    <= cnt_q + 1'b1;
      active_q <= full || (cnt_q < mask);
    end
  end
endmodule

// File: rtl/sdram_col_mem.sv
module sdram_col_mem #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              rvld,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end

  always_ff @(posedge clk) begin
    if (rst) rvld <= 1'b0;
    else     rvld <= re;
  end
endmodule

// File: rtl/sdram_rd_pipe.sv
module sdram_rd_pipe #(
  parameter int DATA_W  = 16,
  parameter int MIN_LAT = 2,
  parameter int MAX_LAT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        lat,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_data
);
  // The memory read register is the first delay; stages add the rest.
  localparam int STAGES = MAX_LAT - 1;

  logic              v_q [STAGES];
  logic [DATA_W-1:0] d_q [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst) v_q[0] <= 1'b0;
          else     v_q[0] <= in_vld;
          d_q[0] <= in_data;
        end
      end else begin : g_tail
        always_ff @(posedge clk) begin
          if (rst) v_q[i] <= 1'b0;
          else     v_q[i] <= v_q[i-1];
          d_q[i] <= d_q[i-1];
        end
      end
    end
  endgenerate

  always_comb begin
    out_vld  = 1'b0;
    out_data = d_q[0];
    for (int i = 0; i < STAGES; i++) begin
      if (int'(lat) == i + MIN_LAT) begin
        out_vld  = v_q[i];
        out_data = d_q[i];
      end
    end
  end
endmodule

// File: rtl/sdram_col_seq.sv
module sdram_col_seq
  import sdram_col_pkg::*;
#(
  parameter int COL_W   = 9,
  parameter int BANK_W  = 2,
  parameter int DATA_W  = 16,
  parameter int MIN_LAT = 2,
  parameter int MAX_LAT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cmd,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic [2:0]        mode_bl,
  input  logic              mode_il,
  input  logic [1:0]        mode_lat,
  input  logic [DATA_W-1:0] wr_data,
  output logic              col_vld,
  output logic              col_wr,
  output logic [BANK_W-1:0] col_bank,
  output logic [COL_W-1:0]  col_addr,
  output logic              rd_vld,
  output logic [DATA_W-1:0] rd_data
);
  localparam int ADDR_W = BANK_W + COL_W;

  mode_t             mode;
  logic              is_rd, is_wr;
  logic              beat_go, beat_wr;
  logic [COL_W-1:0]  beat_col;
  logic [BANK_W-1:0] beat_bank;
  logic              mem_vld;
  logic [DATA_W-1:0] mem_data;

  assign is_rd = (cmd == CMD_READ);
  assign is_wr = (cmd == CMD_WRITE);

  sdram_mode_reg #(.MIN_LAT(MIN_LAT), .MAX_LAT(MAX_LAT)) u_mode (
    .clk(clk), .rst(rst), .load(cmd == CMD_MODE),
    .bl_in(mode_bl), .il_in(mode_il), .lat_in(mode_lat), .mode(mode)
  );

  sdram_burst_gen #(.COL_W(COL_W), .BANK_W(BANK_W)) u_gen (
    .clk(clk), .rst(rst), .mode(mode),
    .start(is_rd || is_wr), .stop(cmd == CMD_STOP), .start_wr(is_wr),
    .start_col(cmd_col), .start_bank(cmd_bank),
    .beat_go(beat_go), .beat_wr(beat_wr), .beat_col(beat_col), .beat_bank(beat_bank)
  );

  sdram_col_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .rst(rst),
    .we(beat_go && beat_wr), .re(beat_go && !beat_wr),
    .addr({beat_bank, beat_col}), .wdata(wr_data),
    .rvld(mem_vld), .rdata(mem_data)
  );

  sdram_rd_pipe #(.DATA_W(DATA_W), .MIN_LAT(MIN_LAT), .MAX_LAT(MAX_LAT)) u_pipe (
    .clk(clk), .rst(rst), .lat(mode.lat),
    .in_vld(mem_vld), .in_data(mem_data),
    .out_vld(rd_vld), .out_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      col_vld  <= 1'b0;
      col_wr   <= 1'b0;
      col_bank <= '0;
      col_addr <= '0;
    end else begin
      col_vld  <= beat_go;
      col_wr   <= beat_go && beat_wr;
      col_bank <= beat_bank;
      col_addr <= beat_col;
    end
  end
endmodule

// File: rtl/sdram_col_seq_chk.sv
module sdram_col_seq_chk
  import sdram_col_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int BANK_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        cmd,
  input logic [BANK_W-1:0] cmd_bank,
  input logic [COL_W-1:0]  cmd_col,
  input logic              col_vld,
  input logic              col_wr,
  input logic [BANK_W-1:0] col_bank,
  input logic [COL_W-1:0]  col_addr,
  input logic              rd_vld
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!armed)
    $past(rst) |-> (!col_vld && !rd_vld)); // R11

  AST_CMD_TAKES_OVER: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_READ || cmd == CMD_WRITE) |=>
      (col_vld && col_addr == $past(cmd_col) && col_bank == $past(cmd_bank))); // R10

  AST_WRITE_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_WRITE) |=> col_wr); // R12

  AST_STOP_HALTS: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_STOP) |=> !col_vld); // R9

  AST_READ_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    rd_vld |-> ($past(col_vld && !col_wr) || $past(col_vld && !col_wr, 2))); // R7
endmodule

bind sdram_col_seq sdram_col_seq_chk #(.COL_W(COL_W), .BANK_W(BANK_W)) u_chk (
  .clk(clk), .rst(rst), .cmd(cmd), .cmd_bank(cmd_bank), .cmd_col(cmd_col),
  .col_vld(col_vld), .col_wr(col_wr), .col_bank(col_bank), .col_addr(col_addr),
  .rd_vld(rd_vld)
);

// File: tb/sdram_col_seq_tb.sv
module sdram_col_seq_tb;
  localparam int NCOL = 512;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  cmd = 3'd0;
  logic [1:0]  cmd_bank = '0;
  logic [8:0]  cmd_col = '0;
  logic [2:0]  mode_bl = '0;
  logic        mode_il = 1'b0;
  logic [1:0]  mode_lat = 2'd2;
  logic [15:0] wr_data = '0;
  logic        col_vld, col_wr, rd_vld;
  logic [1:0]  col_bank;
  logic [8:0]  col_addr;
  logic [15:0] rd_data;

  sdram_col_seq u_dut (
    .clk(clk), .rst(rst), .cmd(cmd), .cmd_bank(cmd_bank), .cmd_col(cmd_col),
    .mode_bl(mode_bl), .mode_il(mode_il), .mode_lat(mode_lat), .wr_data(wr_data),
    .col_vld(col_vld), .col_wr(col_wr), .col_bank(col_bank), .col_addr(col_addr),
    .rd_vld(rd_vld), .rd_data(rd_data)
  );

  always #4 clk = ~clk;

  int    n_chk = 0, n_fail = 0, cyc = 0;
  string cur_tag = "R2";

  // Reference model state.
  int          m_bl = 0, m_il = 0, m_lat = 2;
  int          m_len, m_n, m_base, m_bank;
  bit          m_act = 0, m_wr = 0, m_full;
  bit          e_vld = 0, e_wr = 0;
  int          e_col = 0, e_bank = 0;
  logic [15:0] ref_mem [4*NCOL];
  bit          ref_known [4*NCOL];
  bit          p_v [3];
  bit          p_k [3];
  logic [15:0] p_d [3];

  function automatic int blen(int code);
    return (code == 7) ? NCOL : (1 << code);
  endfunction

  function automatic int beat_col(int base, int n, int code, int il);
    int len = blen(code);
    if (il != 0) return base ^ n;
    return base - (base % len) + ((base % len + n) % len);
  endfunction

  function automatic bit mode_legal(int bl, int il, int lat);
    return ((bl <= 3) || (bl == 7 && il == 0)) && (lat == 2 || lat == 3);
  endfunction

  always @(posedge clk) begin
    bit go;
    int a;
    if (rst) begin
      m_bl = 0; m_il = 0; m_lat = 2; m_act = 0; e_vld = 0; e_wr = 0;
      for (int i = 0; i < 3; i++) p_v[i] = 0;
    end else begin
      go = 0;
      m_full = (m_bl == 7);
      m_len = blen(m_bl);
      if (cmd == 3'd2 || cmd == 3'd3) begin
        go = 1; m_base = int'(cmd_col); m_bank = int'(cmd_bank); m_wr = (cmd == 3'd3);
        m_n = 0; e_col = m_base;
      end else if (cmd == 3'd4) begin
        m_act = 0;
      end else if (m_act) begin
        go = 1; e_col = beat_col(m_base, m_n, m_bl, m_il);
      end
      if (go) begin
        m_act = m_full || (m_n + 1 < m_len);
        m_n++;
        e_bank = m_bank;
      end
      e_vld = go;
      e_wr = go && m_wr;
      a = e_bank * NCOL + e_col;
      p_v[2] = p_v[1]; p_d[2] = p_d[1]; p_k[2] = p_k[1];
      p_v[1] = p_v[0]; p_d[1] = p_d[0]; p_k[1] = p_k[0];
      p_v[0] = go && !m_wr; p_d[0] = ref_mem[a]; p_k[0] = ref_known[a];
      if (go && m_wr) begin
        ref_mem[a] = wr_data; ref_known[a] = 1;
      end
      if (cmd == 3'd1 && mode_legal(int'(mode_bl), int'(mode_il), int'(mode_lat))) begin
        m_bl = int'(mode_bl); m_il = int'(mode_il); m_lat = int'(mode_lat);
      end
    end
  end

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      string atag;
      atag = (m_bl == 7) ? "R5" : (m_il != 0) ? "R4" : "R3";
      chk(col_vld == e_vld, cur_tag, "col_vld", int'(col_vld), int'(e_vld));
      if (e_vld) begin
        chk(int'(col_addr) == e_col, atag, "col_addr", int'(col_addr), e_col);
        chk(int'(col_bank) == e_bank, "R1", "col_bank", int'(col_bank), e_bank);
        chk(col_wr == e_wr, "R12", "col_wr", int'(col_wr), int'(e_wr));
      end
      chk(rd_vld == p_v[m_lat-1], (cur_tag == "R9") ? "R9" : "R7", "rd_vld",
          int'(rd_vld), int'(p_v[m_lat-1]));
      if (p_v[m_lat-1] && p_k[m_lat-1])
        chk(rd_data == p_d[m_lat-1], "R8", "rd_data", int'(rd_data), int'(p_d[m_lat-1]));
    end
  end

  task automatic step(logic [2:0] c, logic [1:0] b = 2'd0, logic [8:0] col = 9'd0);
    @(negedge clk);
    cmd = c; cmd_bank = b; cmd_col = col; wr_data = 16'($urandom);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(3'd0);
  endtask

  task automatic set_mode(int bl, int il, int lat);
    @(negedge clk);
    cmd = 3'd1; mode_bl = 3'(bl); mode_il = il[0]; mode_lat = 2'(lat);
  endtask

  initial begin
    #1500000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4*NCOL; i++) ref_known[i] = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R11: outputs idle right after reset, default mode is 1 beat at latency 2.
    chk(!col_vld && !rd_vld, "R11", "outputs after reset", int'(col_vld || rd_vld), 0);
    cur_tag = "R11";
    step(3'd3, 2'd1, 9'd77);
    step(3'd2, 2'd1, 9'd77);
    idle(5);

    // R2 R3 R4 R5 R7 R8: every length, order and latency combination.
    cur_tag = "R2";
    for (int il = 0; il < 2; il++)
      for (int k = 0; k < 5; k++)
        for (int lat = 2; lat <= 3; lat++) begin
          int bc = (k == 4) ? 7 : k;
          logic [8:0] c0 = 9'($urandom);
          logic [1:0] b0 = 2'($urandom);
          if (il == 1 && bc == 7) continue;
          if (bc == 7) c0 = 9'd505;
          set_mode(bc, il, lat);
          idle(2);
          step(3'd3, b0, c0);
          if (bc == 7) begin idle(20); step(3'd4); end
          idle(blen(bc == 7 ? 0 : bc) + 2);
          step(3'd2, b0, c0);
          if (bc == 7) begin idle(20); step(3'd4); end
          idle(12);
        end

    // R6: illegal mode commands leave 8-beat sequential at latency 3 in force.
    cur_tag = "R6";
    set_mode(3, 0, 3);
    set_mode(5, 0, 2);
    set_mode(7, 1, 3);
    set_mode(2, 0, 1);
    idle(1);
    step(3'd2, 2'd2, 9'd13);
    idle(14);

    // R9: stop on the fourth beat; queued read words still drain at latency 3.
    cur_tag = "R9";
    step(3'd2, 2'd3, 9'd100);
    idle(2);
    step(3'd4);
    idle(8);

    // R10: a write replaces a running read, then a read replaces that write.
    cur_tag = "R10";
    step(3'd2, 2'd0, 9'd40);
    idle(2);
    step(3'd3, 2'd1, 9'd203);
    idle(1);
    step(3'd2, 2'd1, 9'd203);
    idle(14);

    // Random mix of commands, including illegal mode commands (R6).
    cur_tag = "R2";
    for (int i = 0; i < 5000; i++) begin
      int r = int'($urandom % 100);
      if (r < 8) step(3'd4);
      else if (r < 20) step(3'd2, 2'($urandom), 9'($urandom));
      else if (r < 34) step(3'd3, 2'($urandom), 9'($urandom));
      else if (r < 40 && !m_act && !p_v[0] && !p_v[1] && !p_v[2])
        set_mode(int'($urandom % 8), int'($urandom % 2), int'($urandom % 4));
      else step(3'd0);
    end
    step(3'd4);
    idle(6);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule